// File: doc/BRIEF.md
# Configuration ROM Read Address Mapper

This block sits between the serial-bus request decoder and the host memory reader. It claims read requests whose 48-bit destination offset falls in the 1 KB configuration ROM window, from 0xFFFF_F000_0400 to 0xFFFF_F000_07FF. Each claimed request is classified as a memory read, a local header read or a reject.

A memory read is issued as a host memory address. That address is a 1 KB-aligned base register plus the low ten offset bits. Words 0 to 4 of the window are the ROM header and bus information block. A valid read to one of them raises a local strobe for a neighbouring register file and does not touch memory. Any other transaction to the window is rejected with a type-error acknowledge.

Requests enter on a valid/ready stream. `req_ready` is low while the link is disabled, or while a response is waiting and `rsp_ready` is low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears as a registered valid/ready beat on the next edge. A response stays in place, unchanged, until `rsp_ready` takes it. The base register is written through a plain write strobe and can always be read.

Top module: `cfgrom_rd_map`

## Requirements
- R1: The base register stores write data bits 31..10. Bits 9..0 always read as zero, and writes to them are ignored.
- R2: After reset, `cfg_rdata` is zero and `rsp_valid` is low.
- R3: While `link_en` is low, `req_ready` is low and no response is produced.
- R4: A single-word read to word index 5..255 (offset bits 9..2) in the window gives a response one edge after the handshake. The response has `rsp_mem_rd`=1, `rsp_local`=0, `rsp_ack`=4'h2 and `rsp_addr` = base + offset[9:0].
- R5: A single-word read to word index 0..4 gives a response with `rsp_local`=1, `rsp_mem_rd`=0, `rsp_ack`=4'h2 and `rsp_addr` = offset[9:0] zero-extended.
- R6: A single-word read is either transaction code 4'h4, or transaction code 4'h5 with a length of exactly 4. In both cases offset bits 1..0 must be zero. Any other request in the window gives `rsp_ack`=4'hE, `rsp_mem_rd`=0, `rsp_local`=0 and `rsp_addr`=0.
- R7: A request whose offset bits 47..10 do not match the window is consumed and produces no response.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_en | input | 1 | Link enable; requests are serviced only while high |
| cfg_wr | input | 1 | Base register write strobe |
| cfg_wdata | input | 32 | Base register write data |
| cfg_rdata | output | 32 | Base register read value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_offset | input | 48 | Request destination offset |
| req_tcode | input | 4 | Request transaction code |
| req_len | input | 16 | Request data length in bytes |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_mem_rd | output | 1 | Response is a host memory read |
| rsp_local | output | 1 | Response is a local header word read |
| rsp_ack | output | 4 | Acknowledge code: 4'h2 pending, 4'hE reject |
| rsp_addr | output | 32 | Host address, or header byte offset |

## Verification
Every one of the 256 window words is read with an aligned quadlet read under two base values: one low and one near the top of the address space. This separates the header carve-out from the memory path and exercises the adder at both ends. A selection of words is also hit with a block read of length 4, a block read of length 8, a misaligned offset, a write code and an offset just outside the window. These tell apart the legal single-word forms, the reject path and the unclaimed case. Separate passes hold `rsp_ready` low to watch stall behaviour and drop `link_en` to watch the request side stay closed.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam logic [3:0] TC_QUAD_RD  = 4'h4;
  localparam logic [3:0] TC_BLOCK_RD = 4'h5;
  localparam logic [3:0] ACK_PEND    = 4'h2;
  localparam logic [3:0] ACK_REJECT  = 4'hE;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    K_MEM    = 2'd0,
    K_LOCAL  = 2'd1,
    K_REJECT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/cfgrom_base_reg.sv
module cfgrom_base_reg #(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base
);
  logic [AW-ALIGN-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hi_q <= '0;
    else if (wr) hi_q <= wdata[AW-1:ALIGN];
  end

  assign base = {hi_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/cfgrom_decode.sv
module cfgrom_decode
  import cfgrom_pkg::*;
#(
  parameter int unsigned        OFF_W     = 48,
  parameter int unsigned        WIN_AW    = 10,
  parameter logic [OFF_W-1:0]   WIN_BASE  = 48'hFFFF_F000_0400,
  parameter int unsigned        HDR_WORDS = 5,
  parameter int unsigned        LEN_W     = 16
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [3:0]       tcode,
  input  logic [LEN_W-1:0] len,
  output logic             hit,
  output rsp_kind_e        kind
);
  localparam int unsigned IDX_W = WIN_AW - 2;
  localparam logic [OFF_W-WIN_AW-1:0] WIN_TAG = WIN_BASE[OFF_W-1:WIN_AW];

  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  logic             single;
  logic             header;

  assign word_idx = offset[WIN_AW-1:2];
  assign aligned  = (offset[1:0] == 2'b00);
  assign single   = (tcode == TC_QUAD_RD) ||
                    ((tcode == TC_BLOCK_RD) && (len == LEN_W'(WORD_BYTES)));
  assign header   = (int'(word_idx) < int'(HDR_WORDS));
  assign hit      = (offset[OFF_W-1:WIN_AW] == WIN_TAG);

  always_comb begin
    if (!(single && aligned)) kind = K_REJECT;
    else if (header)          kind = K_LOCAL;
    else                      kind = K_MEM;
  end
endmodule

// File: rtl/cfgrom_rsp_stage.sv
module cfgrom_rsp_stage
  import cfgrom_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          take,
  input  rsp_kind_e     kind,
  input  logic [AW-1:0] addr,
  output logic          valid,
  output logic          mem_rd,
  output logic          local_rd,
  output logic [3:0]    ack,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      mem_rd   <= 1'b0;
      local_rd <= 1'b0;
      ack      <= '0;
      addr_q   <= '0;
    end else if (load) begin
      valid    <= 1'b1;
      mem_rd   <= (kind == K_MEM);
      local_rd <= (kind == K_LOCAL);
      ack      <= (kind == K_REJECT) ? ACK_REJECT : ACK_PEND;
      addr_q   <= (kind == K_REJECT) ? '0 : addr;
    end else if (take) begin
      valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgrom_rd_map.sv
module cfgrom_rd_map
  import cfgrom_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned OFF_W     = 48,
  parameter int unsigned WIN_AW    = 10,
  parameter int unsigned HDR_WORDS = 5,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_en,
  input  logic             cfg_wr,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [3:0]       req_tcode,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_mem_rd,
  output logic             rsp_local,
  output logic [3:0]       rsp_ack,
  output logic [AW-1:0]    rsp_addr
);
  localparam logic [OFF_W-1:0] WIN_BASE = OFF_W'(48'hFFFF_F000_0400);

  logic [AW-1:0] base;
  logic          hit;
  rsp_kind_e     kind;
  logic          fire;
  logic [AW-1:0] win_off;
  logic [AW-1:0] addr_n;

  cfgrom_base_reg #(.AW(AW), .ALIGN(WIN_AW)) u_base (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .base(base)
  );

  cfgrom_decode #(
    .OFF_W(OFF_W), .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE),
    .HDR_WORDS(HDR_WORDS), .LEN_W(LEN_W)
  ) u_dec (
    .offset(req_offset), .tcode(req_tcode), .len(req_len),
    .hit(hit), .kind(kind)
  );

  assign cfg_rdata = base;
  assign req_ready = link_en && (!rsp_valid || rsp_ready);
  assign fire      = req_valid && req_ready;
  assign win_off   = {{(AW-WIN_AW){1'b0}}, req_offset[WIN_AW-1:0]};
  assign addr_n    = (kind == K_MEM) ? (base + win_off) : win_off;

  cfgrom_rsp_stage #(.AW(AW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load(fire && hit), .take(rsp_ready),
    .kind(kind), .addr(addr_n),
    .valid(rsp_valid), .mem_rd(rsp_mem_rd), .local_rd(rsp_local),
    .ack(rsp_ack), .addr_q(rsp_addr)
  );
endmodule

// File: rtl/cfgrom_rd_map_chk.sv
module cfgrom_rd_map_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 48,
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_en,
  input logic             cfg_wr,
  input logic [AW-1:0]    cfg_wdata,
  input logic [AW-1:0]    cfg_rdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_offset,
  input logic [3:0]       req_tcode,
  input logic [LEN_W-1:0] req_len,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_mem_rd,
  input logic             rsp_local,
  input logic [3:0]       rsp_ack,
  input logic [AW-1:0]    rsp_addr
);
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[9:0] == 10'd0);

  a_r3_closed_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |-> !req_ready);

  a_r3_no_new_rsp_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_en && !rsp_valid) |=> !rsp_valid);

  a_r4_mem_ack_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mem_rd) |-> (rsp_ack == 4'h2 && !rsp_local));

  a_r5_local_ack_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_local) |-> (rsp_ack == 4'h2 && rsp_addr < 32'd20));

  a_r6_reject_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_mem_rd && !rsp_local) |-> (rsp_ack == 4'hE && rsp_addr == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                   $stable(rsp_ack) && $stable(rsp_mem_rd) &&
                                   $stable(rsp_local)));

  a_r8_stall_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind cfgrom_rd_map cfgrom_rd_map_chk #(.AW(AW), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/cfgrom_rd_map_tb.sv
module cfgrom_rd_map_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [47:0] WIN = 48'hFFFF_F000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_offset = '0;
  logic [3:0]  req_tcode = '0;
  logic [15:0] req_len = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_mem_rd;
  logic        rsp_local;
  logic [3:0]  rsp_ack;
  logic [31:0] rsp_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgrom_rd_map u_dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_base(logic [31:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // Send one request (link on, rsp_ready high) and compare the response.
  task automatic probe(string req, logic [31:0] base, logic [47:0] off,
                       logic [3:0] tc, logic [15:0] len);
    logic        in_win, single, aligned;
    logic [7:0]  idx;
    logic [38:0] exp;
    in_win  = ((off >> 10) == (WIN >> 10));
    aligned = (off % 4) == 0;
    single  = (tc == 4'h4) || (tc == 4'h5 && len == 16'd4);
    idx     = 8'((off % 1024) / 4);
    if (!(single && aligned))
      exp = {1'b1, 1'b0, 1'b0, 4'hE, 32'd0};
    else if (idx < 5)
      exp = {1'b1, 1'b0, 1'b1, 4'h2, 32'(off % 1024)};
    else
      exp = {1'b1, 1'b1, 1'b0, 4'h2, base + 32'(off % 1024)};
    @(negedge clk);
    req_valid = 1'b1; req_offset = off; req_tcode = tc; req_len = len;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (in_win)
      chk(req, 64'({rsp_valid, rsp_mem_rd, rsp_local, rsp_ack, rsp_addr}), 64'(exp));
    else
      chk(req, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [2];
    logic [31:0] held;
    bases[0] = 32'h0001_2C00;
    bases[1] = 32'hFFFF_F800;

    repeat (3) @(negedge clk);
    chk("R2 cfg_rdata after reset", 64'(cfg_rdata), 64'd0);
    chk("R2 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;

    // R1: low bits drop, high bits kept
    wr_base(32'hFFFF_FFFF);
    chk("R1 low bits ignored", 64'(cfg_rdata), 64'hFFFF_FC00);
    wr_base(32'h1234_57FF);
    chk("R1 high bits stored", 64'(cfg_rdata), 64'h1234_5400);

    // R3: link disabled
    @(negedge clk);
    req_valid = 1'b1; req_offset = WIN + 48'd40; req_tcode = 4'h4; req_len = 16'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 req_ready low while link off", 64'(req_ready), 64'd0);
      chk("R3 no response while link off", 64'(rsp_valid), 64'd0);
    end
    req_valid = 1'b0;
    link_en = 1'b1;

    // R4/R5: sweep all words under two bases
    for (int b = 0; b < 2; b++) begin
      wr_base(bases[b]);
      for (int w = 0; w < 256; w++)
        probe(w < 5 ? "R5 header quad read" : "R4 mem quad read",
              bases[b], WIN + 48'(w*4), 4'h4, 16'd0);
    end

    // R6/R7 and single-word block reads on selected words
    for (int w = 0; w < 256; w += 17) begin
      probe("R6 block read len 4 accepted", bases[1], WIN + 48'(w*4), 4'h5, 16'd4);
      probe("R6 block read len 8 rejected", bases[1], WIN + 48'(w*4), 4'h5, 16'd8);
      probe("R6 misaligned rejected", bases[1], WIN + 48'(w*4) + 48'd2, 4'h4, 16'd0);
      probe("R6 write code rejected", bases[1], WIN + 48'(w*4), 4'h0, 16'd0);
      probe("R7 below window", bases[1], WIN - 48'd1024 + 48'(w*4), 4'h4, 16'd0);
      probe("R7 above window", bases[1], WIN + 48'd1024 + 48'(w*4), 4'h4, 16'd0);
    end

    // R8: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_offset = WIN + 48'd400; req_tcode = 4'h4;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    held = rsp_addr;
    chk("R8 stalled response present", 64'(rsp_valid), 64'd1);
    chk("R8 stalled address value", 64'(held), 64'(bases[1] + 32'd400));
    req_valid = 1'b1; req_offset = WIN + 48'd100;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 req_ready low on stall", 64'(req_ready), 64'd0);
      chk("R8 addr held", 64'(rsp_addr), 64'(held));
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 drained after ready", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule